// File: doc/BRIEF.md
# Block-Transfer DMA Channel

This block is one DMA channel that moves data in whole blocks. Software programs a source address, a destination address, a block size in units, and a number of blocks. It then sets the activation bit. Each pulse on the peripheral request input starts one complete block. A block is a run of unit transfers issued back to back on a single-beat bus master. Each unit is one read from the source followed by one write of that same data to the destination. Both addresses step by one after every unit, and they carry on across block boundaries.

A block runs to completion once it has started. Only an NMI, a standby entry or a reset can stop it early. An NMI abort raises a sticky block-error flag. Software stops the channel by writing 0 to the activation bit. The bit keeps reading 1 until the sequencer has reached a safe point, so software writes 0, polls until the bit reads 0, and only then reprograms the channel. When the last block finishes, an interrupt-request flag is set in the same cycle that the channel goes inactive. The interrupt line follows that flag when interrupts are enabled. A later accepted activation clears the flag.

The sequencer has four states:
- IDLE: the channel is inactive.
- ARMED: the channel is active and waiting for a request.
- READ: a read bus cycle is in flight.
- WRITE: a write bus cycle is in flight.

Its transitions are:
- activate: IDLE to ARMED.
- accept: ARMED to READ, on a request.
- read-done: READ to WRITE.
- next-unit: WRITE to READ, when the block has units left.
- block-done: WRITE to ARMED.
- finish: WRITE to IDLE, after the last unit of the last block.
- stop: ARMED or WRITE to IDLE, on a software stop.
- abort: READ or WRITE to IDLE, on an NMI.
- sleep: any state to IDLE, on standby.

Top module: `dma_blk_chan`

## Requirements
- R1: After reset the activation bit, the block-error flag, the interrupt-request flag, the interrupt line and the bus request are all 0.
- R2: A write to select 0 with bit 0 set activates the channel, and the activation bit reads 1 one cycle after the write. The activation is ignored if the block size or the block count is zero. Select 0 is control: bit 0 activate, bit 1 interrupt enable, bit 2 block error. Select 1 is the source address. Select 2 is the destination address. Select 3 holds the block size in bits 7:0 and the block count in bits 15:8.
- R3: Each request accepted while armed runs exactly block-size units, with no gap. Unit k of the whole run reads source+k and writes that data to destination+k. Addresses wrap modulo 2^16.
- R4: A bus cycle holds its request and address until ready is high, unless standby is asserted.
- R5: An NMI during a block ends the transfer at the next ready handshake. At that point the activation bit drops to 0 and the block-error flag is set. A control write with bit 2 at 0 clears the flag.
- R6: The interrupt-request flag is set at the edge that completes the final write of the last block, which is the same edge on which the activation bit falls. The interrupt line is high exactly when the flag and the enable bit are both 1.
- R7: An accepted activation clears the interrupt-request flag.
- R8: Writes to selects 1 to 3 while the activation bit is 1 have no effect.
- R9: A stop write (select 0, bit 0 at 0) behaves as follows:
  - While armed, the activation bit reads 0 one cycle later.
  - Inside a block, the bit stays 1 until the block completes, and the interrupt-request flag is set only if that block was the last one.
- R10: Standby returns the channel to IDLE at the next edge, without setting either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby entry; halts the channel |
| nmi | input | 1 | Non-maskable interrupt; aborts a block |
| dreq | input | 1 | Peripheral transfer request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| act_o | output | 1 | Activation bit read-back |
| blk_err_o | output | 1 | Block-error flag |
| irq_flag_o | output | 1 | Interrupt-request flag |
| irq_o | output | 1 | Interrupt line |
| m_req | output | 1 | Bus cycle request |
| m_we | output | 1 | Bus cycle is a write |
| m_addr | output | 16 | Bus address |
| m_wdata | output | 16 | Bus write data |
| m_rdata | input | 16 | Bus read data |
| m_ready | input | 1 | Bus cycle completes this edge |

## Verification
The timing of each result, counted from the edge that takes in its stimulus, is as follows:
- The activation bit responds to a control write one edge after the write, whether the write activates the channel or stops it from ARMED.
- An accepted request enters READ on the next edge.
- With ready held high, each unit takes two edges.
- The interrupt-request flag, the interrupt line and the falling activation bit all appear on the edge of the final write handshake.

The bench drives every input and samples every output on the falling clock edge. It waits at least one full unit time past each predicted edge before it compares. Where an exact cycle matters, such as the activation bit one cycle after a write or a stalled bus cycle, it samples at the first falling edge after the predicted rising edge.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_RD    = 2'd2,
        S_WR    = 2'd3
    } seq_state_e;

    localparam logic [1:0] SEL_CTL = 2'd0;
    localparam logic [1:0] SEL_SRC = 2'd1;
    localparam logic [1:0] SEL_DST = 2'd2;
    localparam logic [1:0] SEL_CNT = 2'd3;

    localparam int BIT_ACT = 0;
    localparam int BIT_IE  = 1;
    localparam int BIT_ERR = 2;
endpackage

// File: rtl/dma_blk_cfg.sv
module dma_blk_cfg
    import dma_blk_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          act,
    output logic [AW-1:0] src_base,
    output logic [AW-1:0] dst_base,
    output logic [CW-1:0] blk_size,
    output logic [CW-1:0] blk_num,
    output logic          ie
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_base <= '0;
            dst_base <= '0;
            blk_size <= '0;
            blk_num  <= '0;
            ie       <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel == SEL_CTL) begin
                ie <= wr_data[BIT_IE];
            end else if (!act) begin
                unique case (wr_sel)
                    SEL_SRC: src_base <= wr_data[AW-1:0];
                    SEL_DST: dst_base <= wr_data[AW-1:0];
                    default: begin
                        blk_size <= wr_data[CW-1:0];
                        blk_num  <= wr_data[2*CW-1:CW];
                    end
                endcase
            end
        end
    end

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(act) |-> ($stable(src_base) && $stable(dst_base) &&
                        $stable(blk_size) && $stable(blk_num)));
endmodule

// File: rtl/dma_blk_path.sv
module dma_blk_path #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          blk_start,
    input  logic          rd_cap,
    input  logic          step,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] blk_size,
    input  logic [CW-1:0] blk_num,
    input  logic [DW-1:0] m_rdata,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [DW-1:0] hold_data,
    output logic          last_unit,
    output logic          last_block
);
    logic [CW-1:0] units_left;
    logic [CW-1:0] blocks_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_src     <= '0;
            cur_dst     <= '0;
            units_left  <= '0;
            blocks_left <= '0;
            hold_data   <= '0;
        end else begin
            if (load) begin
                cur_src     <= src_base;
                cur_dst     <= dst_base;
                blocks_left <= blk_num;
            end
            if (blk_start) units_left <= blk_size;
            if (rd_cap) hold_data <= m_rdata;
            if (step) begin
                cur_src    <= cur_src + 1'b1;
                cur_dst    <= cur_dst + 1'b1;
                units_left <= units_left - 1'b1;
                if (units_left == 1) blocks_left <= blocks_left - 1'b1;
            end
        end
    end

    assign last_unit  = (units_left == 1);
    assign last_block = (blocks_left == 1);

    // R3
    no_unit_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (units_left != 0 && blocks_left != 0));
endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
    import dma_blk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic nmi,
    input  logic dreq,
    input  logic ctl_wr,
    input  logic ctl_act,
    input  logic ctl_err,
    input  logic cfg_ok,
    input  logic ie,
    input  logic m_ready,
    input  logic last_unit,
    input  logic last_block,
    output logic act,
    output logic berr,
    output logic irf,
    output logic irq,
    output logic m_req,
    output logic m_we,
    output logic load,
    output logic blk_start,
    output logic rd_cap,
    output logic step
);
    seq_state_e state, state_n;
    logic stop_pend, nmi_pend, stop_req, abort, set_err, set_irf;

    assign stop_req = stop_pend | (ctl_wr & ~ctl_act);
    assign abort    = nmi | nmi_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n   = state;
        load      = 1'b0;
        blk_start = 1'b0;
        rd_cap    = 1'b0;
        step      = 1'b0;
        set_err   = 1'b0;
        set_irf   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (ctl_wr && ctl_act && cfg_ok && !standby) begin
                    state_n = S_ARMED;
                    load    = 1'b1;
                end
            end
            S_ARMED: begin
                if (standby || nmi || stop_req) begin
                    state_n = S_IDLE;
                end else if (dreq) begin
                    state_n   = S_RD;
                    blk_start = 1'b1;
                end
            end
            S_RD: begin
                if (standby) begin
                    state_n = S_IDLE;
                end else if (m_ready) begin
                    rd_cap = 1'b1;
                    if (abort) begin
                        state_n = S_IDLE;
                        set_err = 1'b1;
                    end else begin
                        state_n = S_WR;
                    end
                end
            end
            S_WR: begin
                if (standby) begin
                    state_n = S_IDLE;
                end else if (m_ready) begin
                    step = 1'b1;
                    if (abort) begin
                        state_n = S_IDLE;
                        set_err = 1'b1;
                    end else if (!last_unit) begin
                        state_n = S_RD;
                    end else if (last_block) begin
                        state_n = S_IDLE;
                        set_irf = 1'b1;
                    end else if (stop_req) begin
                        state_n = S_IDLE;
                    end else begin
                        state_n = S_ARMED;
                    end
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_pend <= 1'b0;
            nmi_pend  <= 1'b0;
            berr      <= 1'b0;
            irf       <= 1'b0;
        end else begin
            stop_pend <= stop_req && (state_n != S_IDLE);
            nmi_pend  <= abort && (state_n == S_RD || state_n == S_WR);
            if (set_err)                berr <= 1'b1;
            else if (ctl_wr && !ctl_err) berr <= 1'b0;
            if (set_irf)   irf <= 1'b1;
            else if (load) irf <= 1'b0;
        end
    end

    always_comb begin
        act   = (state != S_IDLE);
        m_req = (state == S_RD) || (state == S_WR);
        m_we  = (state == S_WR);
        irq   = irf && ie;
    end

    // R6
    irf_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irf) |-> $fell(act));
    // R5
    err_with_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(berr) |-> $fell(act));
    // R7
    reactivate_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> !irf);
    // R10
    standby_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!act && $stable(berr) && $stable(irf)));
endmodule

// File: rtl/dma_blk_chan.sv
module dma_blk_chan
    import dma_blk_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          nmi,
    input  logic          dreq,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          act_o,
    output logic          blk_err_o,
    output logic          irq_flag_o,
    output logic          irq_o,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ready
);
    logic [AW-1:0] src_base, dst_base, cur_src, cur_dst;
    logic [CW-1:0] blk_size, blk_num;
    logic ie, load, blk_start, rd_cap, step, last_unit, last_block;
    logic ctl_wr, cfg_ok;

    assign ctl_wr = wr_en && (wr_sel == SEL_CTL);
    assign cfg_ok = (blk_size != '0) && (blk_num != '0);

    dma_blk_cfg #(.AW(AW), .DW(DW), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .act(act_o), .src_base(src_base),
        .dst_base(dst_base), .blk_size(blk_size), .blk_num(blk_num), .ie(ie)
    );

    dma_blk_path #(.AW(AW), .DW(DW), .CW(CW)) u_path (
        .clk(clk), .rst_n(rst_n), .load(load), .blk_start(blk_start),
        .rd_cap(rd_cap), .step(step), .src_base(src_base),
        .dst_base(dst_base), .blk_size(blk_size), .blk_num(blk_num),
        .m_rdata(m_rdata), .cur_src(cur_src), .cur_dst(cur_dst),
        .hold_data(m_wdata), .last_unit(last_unit), .last_block(last_block)
    );

    dma_blk_seq u_seq (
        .clk(clk), .rst_n(rst_n), .standby(standby), .nmi(nmi), .dreq(dreq),
        .ctl_wr(ctl_wr), .ctl_act(wr_data[BIT_ACT]), .ctl_err(wr_data[BIT_ERR]),
        .cfg_ok(cfg_ok), .ie(ie), .m_ready(m_ready), .last_unit(last_unit),
        .last_block(last_block), .act(act_o), .berr(blk_err_o),
        .irf(irq_flag_o), .irq(irq_o), .m_req(m_req), .m_we(m_we),
        .load(load), .blk_start(blk_start), .rd_cap(rd_cap), .step(step)
    );

    assign m_addr = m_we ? cur_dst : cur_src;

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready && !standby) |=> (m_req && $stable(m_addr) && $stable(m_we)));
endmodule

// File: tb/test_dma_blk_chan.sv
module test_dma_blk_chan;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0, nmi = 1'b0, dreq = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = '0;
    logic        act_o, blk_err_o, irq_flag_o, irq_o, m_req, m_we, m_ready;
    logic [15:0] m_addr, m_wdata, m_rdata;
    logic        rdy_en = 1'b1;

    int nchk = 0, nfail = 0, nwr = 0;
    logic [15:0] wa [0:255];
    logic [15:0] wd [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign m_ready = m_req && rdy_en;
    assign m_rdata = m_addr ^ 16'h5A5A;

    dma_blk_chan i_dma_blk_chan (
        .clk(clk), .rst_n(rst_n), .standby(standby), .nmi(nmi), .dreq(dreq),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .act_o(act_o),
        .blk_err_o(blk_err_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ready(m_ready)
    );

    always @(posedge clk) begin
        if (rst_n && m_req && m_we && m_ready) begin
            wa[nwr[7:0]] <= m_addr;
            wd[nwr[7:0]] <= m_wdata;
            nwr <= nwr + 1;
        end
    end

    // {src, dst, size, count}
    localparam logic [47:0] VEC [4] = '{
        {16'h0100, 16'h2000, 8'd4, 8'd1},
        {16'h0300, 16'h4000, 8'd1, 8'd3},
        {16'h1234, 16'h6000, 8'd5, 8'd2},
        {16'hFFFE, 16'h7000, 8'd3, 8'd1}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int base, t, exp_n;
        logic ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {act_o, blk_err_o, irq_flag_o, irq_o, m_req}, 5'b0);

        for (int i = 0; i < 4; i++) begin
            logic [15:0] src, dst; logic [7:0] sz, nb; logic ie_v;
            {src, dst, sz, nb} = VEC[i];
            ie_v = i[0];
            wr(2'd1, src); wr(2'd2, dst); wr(2'd3, {nb, sz});
            wr(2'd0, {13'b0, 1'b1, ie_v, 1'b1});
            chk("R2 activate", act_o, 1'b1);
            if (i > 0) chk("R7 flag cleared on activate", irq_flag_o, 1'b0);
            base = nwr;
            for (int b = 0; b < nb; b++) begin
                pulse_req();
                idle(2 * sz + 2);
            end
            exp_n = sz * nb;
            chk("R3 unit count", nwr - base, exp_n);
            ok = 1'b1;
            for (int k = 0; k < exp_n; k++) begin
                if (wa[(base + k) % 256] !== 16'(dst + k)) ok = 1'b0;
                if (wd[(base + k) % 256] !== (16'(src + k) ^ 16'h5A5A)) ok = 1'b0;
            end
            chk("R3 addresses and data", ok, 1'b1);
            chk("R6 done flags", {act_o, irq_flag_o}, 2'b01);
            chk("R6 irq follows enable", irq_o, ie_v);
        end

        // R8 config ignored while active, R4 stalled cycle held
        wr(2'd1, 16'h0500); wr(2'd2, 16'h0800); wr(2'd3, {8'd1, 8'd2});
        wr(2'd0, 16'h0007);
        wr(2'd1, 16'h0900);
        rdy_en = 1'b0;
        pulse_req();
        idle(3);
        chk("R4 stalled read held", {m_req, m_we, m_addr}, {1'b1, 1'b0, 16'h0500});
        chk("R8 source write ignored", m_addr, 16'h0500);
        rdy_en = 1'b1;
        base = nwr;
        idle(6);
        chk("R8 block used old config", {wa[(base + 1) % 256], wd[(base + 1) % 256]},
            {16'h0801, 16'h0501 ^ 16'h5A5A});
        chk("R6 irq asserted", {act_o, irq_o}, 2'b01);

        // R9 stop while armed
        base = nwr;
        wr(2'd0, 16'h0007);
        wr(2'd0, 16'h0006);
        chk("R9 stop while armed", act_o, 1'b0);
        chk("R9 no flag on stop", {irq_flag_o, nwr - base}, 33'd0);

        // R9 stop inside a block
        wr(2'd3, {8'd2, 8'd4});
        wr(2'd0, 16'h0007);
        base = nwr;
        pulse_req();
        idle(1);
        wr(2'd0, 16'h0006);
        chk("R9 still active after stop write", act_o, 1'b1);
        idle(10);
        chk("R9 stopped after block", {act_o, irq_flag_o}, 2'b00);
        chk("R9 block completed", nwr - base, 4);

        // R5 NMI abort
        wr(2'd3, {8'd1, 8'd6});
        wr(2'd0, 16'h0007);
        base = nwr;
        pulse_req();
        idle(2);
        @(negedge clk); nmi = 1'b1;
        @(negedge clk); nmi = 1'b0;
        idle(4);
        t = nwr - base;
        chk("R5 abort flags", {act_o, blk_err_o, irq_flag_o}, 3'b010);
        chk("R5 block cut short", (t > 0 && t < 6), 1'b1);
        wr(2'd0, 16'h0002);
        chk("R5 error cleared by write", blk_err_o, 1'b0);

        // R2 zero size ignored
        wr(2'd3, {8'd1, 8'd0});
        wr(2'd0, 16'h0007);
        chk("R2 zero size ignored", act_o, 1'b0);

        // R10 standby
        wr(2'd3, {8'd1, 8'd6});
        wr(2'd0, 16'h0007);
        pulse_req();
        idle(2);
        @(negedge clk); standby = 1'b1;
        @(negedge clk); standby = 1'b0;
        idle(2);
        chk("R10 standby halts", {act_o, blk_err_o, irq_flag_o, m_req}, 4'b0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule